// File: doc/BRIEF.md
# Reclocker Bring-Up and Lock Supervisor

This controller takes a serial-video reclocker from power-on into register-controlled operation and then watches its lock state. After reset it holds the reclocker's two rate-select pins low, which selects automatic rate detection. It keeps them low for a timed interval that is derived from the clock frequency, and then drives both pins high so that the device accepts register control.

Once the device is in register mode, the controller writes three configuration registers through a simple request port. An SMBus host sits behind that port and carries each transfer to the device. Each written byte keeps the device's mandatory reserved bit values and adds the user's choices: clock output on the secondary driver, output mute, charge-pump current (a higher code gives a wider loop bandwidth) and driver power-down.

After configuration the controller reads the status register at a fixed poll interval. It splits the 4-bit state code into a rate class and an acquisition phase, and reports a locked flag and an error flag.

Top module: `rclk_supervisor`

## Requirements
- R1: After reset, `rate_pin` is 00 for exactly CLK_HZ/1000*PWRUP_MS clock cycles and then 11 until the next reset. During reset, `locked`, `err`, `rate_code` and `acq_phase` are 0.
- R2: No request is issued while `rate_pin` is 00.
- R3: The configuration writes go to addresses 00h, 0Eh and 10h in that order. Each request stays asserted with stable address and data until `req_done`, and the next request starts only after that.
- R4: The byte written to 00h has bits 7:3 at zero, `cfg_mute` at bit 1 and `cfg_sclk_en` at bit 0.
- R5: The byte written to 0Eh is 0001 in bits 7:4, `cfg_cp` in bits 3:2 and 11 in bits 1:0.
- R6: The byte written to 10h is 10000 in bits 7:3, `cfg_pd_main` at bit 2, `cfg_pd_aux` at bit 1 and 0 at bit 0.
- R7: After configuration the block reads address 32h repeatedly. Successive read requests begin no less than POLL_CYC cycles apart. The state code is `req_rdata[7:4]`.
- R8: A valid code sets `rate_code` to code[3:2] (01 SD, 10 HD, 11 3G) and `acq_phase` to code[1:0] (00 coarse, 01 frequency, 10 phase, 11 locked).
- R9: `locked` is 1 only after a valid code whose low two bits are 11. Any other completed read clears it.
- R10: A reserved code (0000 to 0011) sets `err` and clears `locked`, leaves `rate_code` and `acq_phase` unchanged, and polling continues.
- R11: A read that completes with `req_err` sets `err` and clears `locked`. Polling continues and `rate_pin` stays 11.
- R12: A write that completes with `req_err` sets `err`. The list then restarts at 00h after one poll interval, and the power-up phase is not repeated.
- R13: `err` clears on the next read that returns a valid code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sclk_en | input | 1 | Put the clock on the secondary output |
| cfg_mute | input | 1 | Mute the outputs |
| cfg_cp | input | 2 | Charge-pump current code |
| cfg_pd_main | input | 1 | Power down the main output driver |
| cfg_pd_aux | input | 1 | Power down the secondary output driver |
| rate_pin | output | 2 | Rate-select pins of the reclocker |
| req_valid | output | 1 | Register request pending |
| req_write | output | 1 | 1 for a write, 0 for a read |
| req_addr | output | 8 | Register address |
| req_wdata | output | 8 | Write data |
| req_done | input | 1 | One-cycle completion pulse |
| req_err | input | 1 | Completion ended in error, valid with req_done |
| req_rdata | input | 8 | Read data, valid with req_done |
| rate_code | output | 2 | Detected rate class |
| acq_phase | output | 2 | Acquisition phase |
| locked | output | 1 | Device locked |
| err | output | 1 | Last transaction failed or returned a reserved code |

## Verification
A sequencer stuck in the wrong state shows first on `rate_pin`. That pin leaves 00 too early or too late, or falls back to 00, and the bench sees it at the exact cycle of the power-up boundary. An address counter or a reserved-bit pattern that is wrong shows in the first three logged writes as soon as they complete. A decode fault shows on `rate_code`, `acq_phase`, `locked` or `err` one clock after the read's completion pulse. A wrong poll counter shows in the spacing of read requests within two polls.

// File: rtl/rclk_supervisor.sv
module rclk_supervisor #(
  parameter int unsigned CLK_HZ   = 250_000_000,
  parameter int unsigned PWRUP_MS = 300,
  parameter int unsigned POLL_CYC = 250_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_sclk_en,
  input  logic       cfg_mute,
  input  logic [1:0] cfg_cp,
  input  logic       cfg_pd_main,
  input  logic       cfg_pd_aux,
  output logic [1:0] rate_pin,
  output logic       req_valid,
  output logic       req_write,
  output logic [7:0] req_addr,
  output logic [7:0] req_wdata,
  input  logic       req_done,
  input  logic       req_err,
  input  logic [7:0] req_rdata,
  output logic [1:0] rate_code,
  output logic [1:0] acq_phase,
  output logic       locked,
  output logic       err
);
  localparam int unsigned PWRUP_CYC = CLK_HZ / 1000 * PWRUP_MS;
  localparam int unsigned MAX_CYC   = (PWRUP_CYC > POLL_CYC) ? PWRUP_CYC : POLL_CYC;
  localparam int unsigned CNT_W     = $clog2(MAX_CYC) + 1;
  localparam logic [CNT_W-1:0] PW_LAST   = CNT_W'(PWRUP_CYC - 1);
  localparam logic [CNT_W-1:0] POLL_LAST = CNT_W'(POLL_CYC - 1);

  typedef enum logic [1:0] {S_PWRUP, S_CFG, S_WAIT, S_READ} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       idx;
  logic             cfg_ok;

  wire [3:0] code     = req_rdata[7:4];
  wire       reserved = (code[3:2] == 2'b00);

  assign rate_pin  = (st == S_PWRUP) ? 2'b00 : 2'b11;
  assign req_valid = (st == S_CFG) || (st == S_READ);
  assign req_write = (st == S_CFG);

  always_comb begin
    req_addr  = 8'h32;
    req_wdata = 8'h00;
    if (st == S_CFG) begin
      case (idx)
        2'd0:    begin req_addr = 8'h00; req_wdata = {6'b000000, cfg_mute, cfg_sclk_en}; end
        2'd1:    begin req_addr = 8'h0E; req_wdata = {4'b0001, cfg_cp, 2'b11}; end
        default: begin req_addr = 8'h10; req_wdata = {5'b10000, cfg_pd_main, cfg_pd_aux, 1'b0}; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_PWRUP;
      cnt       <= '0;
      idx       <= 2'd0;
      cfg_ok    <= 1'b0;
      rate_code <= 2'b00;
      acq_phase <= 2'b00;
      locked    <= 1'b0;
      err       <= 1'b0;
    end else begin
      case (st)
        S_PWRUP: begin
          if (cnt == PW_LAST) begin
            cnt <= '0;
            st  <= S_CFG;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_CFG: begin
          if (req_done) begin
            if (req_err) begin
              err <= 1'b1;
              idx <= 2'd0;
              st  <= S_WAIT;
            end else if (idx == 2'd2) begin
              cfg_ok <= 1'b1;
              idx    <= 2'd0;
              st     <= S_WAIT;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        S_WAIT: begin
          if (cnt == POLL_LAST) begin
            cnt <= '0;
            st  <= cfg_ok ? S_READ : S_CFG;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (req_done) begin
            st <= S_WAIT;
            if (req_err || reserved) begin
              err    <= 1'b1;
              locked <= 1'b0;
            end else begin
              rate_code <= code[3:2];
              acq_phase <= code[1:0];
              locked    <= &code[1:0];
              err       <= 1'b0;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/rclk_supervisor_chk.sv
module rclk_supervisor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] rate_pin,
  input logic       req_valid,
  input logic       req_write,
  input logic [7:0] req_addr,
  input logic [7:0] req_wdata,
  input logic       req_done,
  input logic       req_err,
  input logic [1:0] acq_phase,
  input logic [1:0] rate_code,
  input logic       locked
);
  // R1
  pins_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_pin == 2'b11) |=> (rate_pin == 2'b11));
  // R2
  quiet_pwrup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_pin == 2'b00) |-> !req_valid);
  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_done) |=> (req_valid && $stable(req_addr) && $stable(req_wdata) && $stable(req_write)));
  // R5
  cp_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == 8'h0E) |-> (req_wdata[7:4] == 4'b0001 && req_wdata[1:0] == 2'b11));
  // R6
  pd_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == 8'h10) |-> (req_wdata[7:3] == 5'b10000 && !req_wdata[0]));
  // R9
  lock_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (acq_phase == 2'b11 && rate_code != 2'b00));
  // R9
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(req_done && !req_err && !req_write));
endmodule

bind rclk_supervisor rclk_supervisor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rate_pin(rate_pin), .req_valid(req_valid),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .req_done(req_done), .req_err(req_err), .acq_phase(acq_phase),
  .rate_code(rate_code), .locked(locked)
);

// File: tb/rclk_supervisor_tb.sv
`timescale 1ns/1ps
module rclk_supervisor_tb;
  localparam int unsigned CLK_HZ = 10_000;
  localparam int unsigned PWMS   = 300;
  localparam int unsigned PW     = CLK_HZ / 1000 * PWMS;
  localparam int unsigned POLL   = 16;
  localparam int          LAT    = 3;

  logic clk = 0, rst_n = 0;
  logic cfg_sclk_en = 0, cfg_mute = 0, cfg_pd_main = 0, cfg_pd_aux = 0;
  logic [1:0] cfg_cp = 0;
  logic [1:0] rate_pin, rate_code, acq_phase;
  logic req_valid, req_write, locked, err;
  logic [7:0] req_addr, req_wdata;
  logic req_done = 0, req_err = 0;
  logic [7:0] req_rdata = 0;

  always #2 clk = ~clk;

  rclk_supervisor #(.CLK_HZ(CLK_HZ), .PWRUP_MS(PWMS), .POLL_CYC(POLL)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_sclk_en(cfg_sclk_en), .cfg_mute(cfg_mute),
    .cfg_cp(cfg_cp), .cfg_pd_main(cfg_pd_main), .cfg_pd_aux(cfg_pd_aux),
    .rate_pin(rate_pin), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_done(req_done),
    .req_err(req_err), .req_rdata(req_rdata), .rate_code(rate_code),
    .acq_phase(acq_phase), .locked(locked), .err(err));

  int checks = 0, errors = 0;
  int cyc = 0;
  logic [7:0] status = 8'h00;
  int inj = 0;
  int wcnt = 0, rcnt = 0, wlog_n = 0;
  logic [15:0] wlog [0:15];
  int last_rd = -1, gap_min = 1 << 30, gap_max = 0;
  logic busy = 0, cur_wr = 0, early_req = 0;
  int lat = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      busy = 0; req_done = 0; req_err = 0;
    end else begin
      if (rate_pin == 2'b00 && req_valid) early_req = 1;
      if (req_done) begin
        req_done = 0; req_err = 0;
      end else if (busy) begin
        if (lat == 0) begin
          req_done = 1;
          req_err  = (inj > 0);
          if (inj > 0) inj--;
          if (cur_wr) wcnt++;
          else begin rcnt++; req_rdata = status; end
          busy = 0;
        end else lat--;
      end else if (req_valid) begin
        busy = 1; lat = LAT; cur_wr = req_write;
        if (req_write) begin
          if (wlog_n < 16) wlog[wlog_n] = {req_addr, req_wdata};
          wlog_n++;
        end else begin
          if (last_rd >= 0) begin
            if (cyc - last_rd < gap_min) gap_min = cyc - last_rd;
            if (cyc - last_rd > gap_max) gap_max = cyc - last_rd;
          end
          last_rd = cyc;
        end
      end
    end
  end

  task automatic wait_reads(input int n);
    int r0 = rcnt;
    wait (rcnt >= r0 + n);
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    wcnt = 0; rcnt = 0; wlog_n = 0; last_rd = -1; early_req = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk(rate_pin == 2'b00, "R1 reset rate_pin", rate_pin, 0);
    chk(!locked && !err, "R1 reset flags", {locked, err}, 0);
    chk(rate_code == 0 && acq_phase == 0, "R1 reset decode", {rate_code, acq_phase}, 0);
  endtask

  task automatic t_powerup();
    rst_n = 1;
    repeat (PW - 1) @(posedge clk);
    @(negedge clk);
    chk(rate_pin == 2'b00, "R1 pins low before interval end", rate_pin, 0);
    @(posedge clk); @(negedge clk);
    chk(rate_pin == 2'b11, "R1 pins high at interval end", rate_pin, 3);
    chk(!early_req, "R2 no request during power-up", early_req, 0);
  endtask

  task automatic t_config(input logic [15:0] e0, input logic [15:0] e1, input logic [15:0] e2, input int base);
    wait (wcnt >= base + 3);
    @(negedge clk);
    chk(wlog[base] == e0, "R4 write 00h", wlog[base], e0);
    chk(wlog[base+1] == e1, "R5 write 0Eh", wlog[base+1], e1);
    chk(wlog[base+2] == e2, "R6 write 10h", wlog[base+2], e2);
    chk(wlog_n == base + 3, "R3 write count", wlog_n, base + 3);
  endtask

  task automatic t_decode(input logic [7:0] s, input logic [1:0] er, input logic [1:0] ep, input bit el, input string tag);
    status = s;
    wait_reads(2);
    chk(rate_code == er, {"R8 rate ", tag}, rate_code, er);
    chk(acq_phase == ep, {"R8 phase ", tag}, acq_phase, ep);
    chk(locked == el, {"R9 locked ", tag}, locked, el);
    chk(!err, {"R13 err clear ", tag}, err, 0);
  endtask

  task automatic t_reserved();
    status = 8'h90;
    wait_reads(2);
    status = 8'h20;
    wait_reads(2);
    chk(err, "R10 reserved sets err", err, 1);
    chk(!locked, "R10 reserved clears locked", locked, 0);
    chk(rate_code == 2'b10 && acq_phase == 2'b01, "R10 decode held", {rate_code, acq_phase}, 4'b1001);
    status = 8'hF0;
    wait_reads(2);
    chk(!err && locked, "R13 recovery after reserved", {err, locked}, 2'b01);
  endtask

  task automatic t_readerr();
    int w0 = wlog_n;
    status = 8'hF0;
    wait_reads(2);
    inj = 1;
    wait_reads(1);
    chk(err && !locked, "R11 read error flags", {err, locked}, 2'b10);
    chk(rate_pin == 2'b11 && wlog_n == w0, "R11 no restart", {rate_pin, 8'(wlog_n)}, {2'b11, 8'(w0)});
    wait_reads(2);
    chk(!err && locked, "R11 polling resumed", {err, locked}, 2'b01);
  endtask

  task automatic t_poll();
    chk(gap_min >= int'(POLL) && gap_max <= int'(POLL) + LAT + 2,
        "R7 poll spacing", gap_min, POLL);
  endtask

  task automatic t_cfgerr();
    do_reset();
    cfg_sclk_en = 0; cfg_mute = 1; cfg_cp = 2'b11; cfg_pd_main = 1; cfg_pd_aux = 0;
    inj = 1;
    rst_n = 1;
    wait (wcnt >= 1);
    @(posedge clk); @(negedge clk);
    chk(err, "R12 write error sets err", err, 1);
    chk(wlog[0] == 16'h0002, "R12 first write", wlog[0], 16'h0002);
    t_config(16'h0002, 16'h0E1F, 16'h1084, 1);
    chk(rate_pin == 2'b11, "R12 no power-up repeat", rate_pin, 3);
    status = 8'hD0;
    wait_reads(2);
    chk(!err && rate_code == 2'b11 && acq_phase == 2'b01, "R13 clear after cfg error",
        {err, rate_code, acq_phase}, 5'b01101);
  endtask

  initial begin
    cfg_sclk_en = 1; cfg_mute = 0; cfg_cp = 2'b10; cfg_pd_main = 0; cfg_pd_aux = 1;
    t_reset();
    t_powerup();
    t_config(16'h0001, 16'h0E1B, 16'h1082, 0);
    t_decode(8'h40, 2'b01, 2'b00, 0, "SD coarse");
    t_decode(8'h90, 2'b10, 2'b01, 0, "HD freq");
    t_decode(8'hF0, 2'b11, 2'b11, 1, "3G locked");
    t_decode(8'hE0, 2'b11, 2'b10, 0, "3G phase");
    t_decode(8'h70, 2'b01, 2'b11, 1, "SD locked");
    t_reserved();
    t_readerr();
    t_poll();
    t_cfgerr();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule